// File: doc/BRIEF.md
# Interrupt Line Trigger-Mode Register and Request Conditioner

This block holds a sixteen-bit trigger-mode map for legacy interrupt lines and applies it to the raw request wires. A byte-wide port bus reaches the map as two adjacent byte registers. The lower byte covers lines 0 to 7 and the upper byte covers lines 8 to 15. Each byte can be read back, and each byte is written on its own.

Every raw line first goes through a two-flop synchronizer. The line's mode bit then decides how the synchronized value is read. In edge mode the line is active-high: a rising edge sets a pending flag, and that flag holds until the matching acknowledge bit is pulsed. In level mode the line is active-low and is passed through inverted, with no acknowledge needed. The block outputs one normalized, active-high request per line, ready for a priority resolver downstream. Five line positions can never leave edge mode.

Top module: `irq_trig_ctl`

## Requirements
- R1: After reset every mode bit is 0, both register bytes read 0, and with all raw inputs low every request output is 0.
- R2: A write at address BASE_ADDR (0x4D0) sets the mode bits of lines 0-7, and a write at BASE_ADDR+1 sets lines 8-15. Data bit b of a byte maps to line 8*lane+b, where 1 means level and 0 means edge. A read with io_rd high at either address returns that byte's current bits in the same cycle.
- R3: The bits for lines 0, 1, 2, 8 and 13 always read 0 and writes to them are ignored, so those lines always behave as edge lines.
- R4: A write to one register byte leaves the other byte unchanged.
- R5: A write or read at any address other than the two register addresses has no effect on the mode bits, and such a read returns 0. While io_rd is low, io_rdata is 0.
- R6: A raw input change reaches the conditioning logic through two flops. A level-mode request follows the raw input after two rising clock edges. An edge-mode request is set after three rising clock edges, because one extra flop is used for edge detection.
- R7: In edge mode, a low-to-high transition of the synchronized input raises the line's request. The request stays high after the input falls again.
- R8: In edge mode, an acknowledge pulse clears the pending request. If the acknowledge arrives in the same cycle as a new rising edge, the request stays set.
- R9: In level mode, the request is the inverse of the synchronized input. An acknowledge has no effect on it.
- R10: Switching a line from edge mode to level mode discards its pending edge request. Switching the line back to edge mode while the input is held high does not raise the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | ADDR_W (12) | Port bus address |
| io_wr | input | 1 | Write strobe, one cycle per byte write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte, 0 when no register is being read |
| irq_raw | input | NUM_LINES (16) | Raw asynchronous interrupt inputs |
| irq_ack | input | NUM_LINES (16) | Per-line acknowledge pulses for edge requests |
| irq_req | output | NUM_LINES (16) | Normalized active-high requests |

## Verification
The bench builds the block with its default parameters: sixteen lines, a twelve-bit address at 0x4D0, and the five-position forced-edge mask. With this configuration, all 256 data values can be swept through each byte port, together with an address window around both ports. Every one of the sixteen lines also runs through the edge, acknowledge, same-cycle re-arm, level-pass and mode-switch sequences. The expected register contents come from a bench-side model that masks the forced positions. The expected request timings come from counting the three flop stages.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

  localparam int BYTE_W = 8;

  // Value stored in one register byte after a write; forced positions stay 0.
  function automatic logic [BYTE_W-1:0] lane_next(input logic [BYTE_W-1:0] wdata,
                                                  input logic [BYTE_W-1:0] forced);
    return wdata & ~forced;
  endfunction

  // Next state of an edge pending flag: set wins over acknowledge.
  function automatic logic pend_next(input logic pend, input logic rise, input logic ack);
    return rise | (pend & ~ack);
  endfunction

  // Normalized request: active-low pass-through in level mode, latched flag in edge mode.
  function automatic logic req_of(input logic level_mode, input logic sync_in, input logic pend);
    return level_mode ? ~sync_in : pend;
  endfunction

endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d_in;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/irq_mode_regs.sv
module irq_mode_regs
  import irq_trig_pkg::*;
#(
  parameter int                    NUM_LINES   = 16,
  parameter int                    ADDR_W      = 12,
  parameter logic [ADDR_W-1:0]     BASE_ADDR   = 12'h4D0,
  parameter logic [NUM_LINES-1:0]  FORCED_EDGE = 16'h2107
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     io_addr,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [BYTE_W-1:0]     io_wdata,
  output logic [BYTE_W-1:0]     io_rdata,
  output logic [NUM_LINES-1:0]  mode_q,
  output logic [NUM_LINES/BYTE_W-1:0] lane_hit
);
  localparam int LANES = NUM_LINES / BYTE_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [BYTE_W-1:0] FMASK = FORCED_EDGE[k*BYTE_W +: BYTE_W];
    logic [BYTE_W-1:0] lane_q;

    assign lane_hit[k] = (io_addr == (BASE_ADDR + ADDR_W'(k)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (io_wr && lane_hit[k]) begin
        lane_q <= lane_next(io_wdata, FMASK);
      end
    end

    assign mode_q[k*BYTE_W +: BYTE_W] = lane_q;
  end

  always_comb begin
    io_rdata = '0;
    for (int k = 0; k < LANES; k++) begin
      if (io_rd && lane_hit[k]) begin
        io_rdata = io_rdata | mode_q[k*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/irq_line_cond.sv
module irq_line_cond
  import irq_trig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic level_mode,
  input  logic ack,
  output logic req,
  output logic pend,
  output logic rise
);
  logic prev_q;
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= sync_in;
    end
  end

  assign rise = sync_in & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (level_mode) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_next(pend_q, rise, ack);
    end
  end

  assign pend = pend_q;
  assign req  = req_of(level_mode, sync_in, pend_q);
endmodule

// File: rtl/irq_trig_ctl.sv
module irq_trig_ctl #(
  parameter int                    NUM_LINES   = 16,
  parameter int                    ADDR_W      = 12,
  parameter logic [ADDR_W-1:0]     BASE_ADDR   = 12'h4D0,
  parameter logic [NUM_LINES-1:0]  FORCED_EDGE = 16'h2107,
  parameter int                    SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     io_addr,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  input  logic [NUM_LINES-1:0]  irq_raw,
  input  logic [NUM_LINES-1:0]  irq_ack,
  output logic [NUM_LINES-1:0]  irq_req
);
  localparam int LANES = NUM_LINES / 8;

  logic [NUM_LINES-1:0] mode_q;
  logic [NUM_LINES-1:0] sync_w;
  logic [NUM_LINES-1:0] pend_w;
  logic [NUM_LINES-1:0] rise_w;
  logic [LANES-1:0]     lane_hit;

  irq_mode_regs #(
    .NUM_LINES  (NUM_LINES),
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR),
    .FORCED_EDGE(FORCED_EDGE)
  ) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .io_wdata(io_wdata),
    .io_rdata(io_rdata),
    .mode_q  (mode_q),
    .lane_hit(lane_hit)
  );

  irq_sync_chain #(
    .W     (NUM_LINES),
    .STAGES(SYNC_STAGES)
  ) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (irq_raw),
    .d_out(sync_w)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    irq_line_cond i_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_in   (sync_w[n]),
      .level_mode(mode_q[n]),
      .ack       (irq_ack[n]),
      .req       (irq_req[n]),
      .pend      (pend_w[n]),
      .rise      (rise_w[n])
    );
  end
endmodule

// File: rtl/irq_trig_chk.sv
module irq_trig_chk #(
  parameter int                    NUM_LINES   = 16,
  parameter logic [NUM_LINES-1:0]  FORCED_EDGE = 16'h2107
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   io_wr,
  input logic                   io_rd,
  input logic [7:0]             io_rdata,
  input logic [NUM_LINES-1:0]   irq_ack,
  input logic [NUM_LINES-1:0]   mode_q,
  input logic [NUM_LINES-1:0]   pend_w,
  input logic [NUM_LINES-1:0]   rise_w,
  input logic [NUM_LINES/8-1:0] lane_hit
);
  localparam int LANES = NUM_LINES / 8;

  // R3
  forced_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q & FORCED_EDGE) == '0);

  // R5
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'h00);

  // R5
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && lane_hit == '0) |-> io_rdata == 8'h00);

  // R5
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && lane_hit == '0) |=> $stable(mode_q));

  for (genvar k = 0; k < LANES; k++) begin : g_keep
    // R4
    lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !lane_hit[k]) |=> $stable(mode_q[k*8 +: 8]));
  end

  // R7
  rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~pend_w & $past(rise_w & ~mode_q)) == '0));

  // R8
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_w & $past(irq_ack & ~rise_w & ~mode_q)) == '0));

  // R10
  level_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_w & $past(mode_q)) == '0));
endmodule

bind irq_trig_ctl irq_trig_chk #(
  .NUM_LINES  (NUM_LINES),
  .FORCED_EDGE(FORCED_EDGE)
) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .io_wr   (io_wr),
  .io_rd   (io_rd),
  .io_rdata(io_rdata),
  .irq_ack (irq_ack),
  .mode_q  (mode_q),
  .pend_w  (pend_w),
  .rise_w  (rise_w),
  .lane_hit(lane_hit)
);

// File: tb/test_irq_trig_ctl.sv
`timescale 1ns/1ps
module test_irq_trig_ctl;
  localparam logic [11:0] BASE = 12'h4D0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] io_addr;
  logic        io_wr, io_rd;
  logic [7:0]  io_wdata, io_rdata;
  logic [15:0] irq_raw, irq_ack, irq_req;

  int total = 0;
  int bad = 0;
  logic [15:0] shadow;
  logic [15:0] forced;

  always #2.5 clk = ~clk;

  irq_trig_ctl i_irq_trig_ctl (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .irq_raw(irq_raw),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    cyc(1);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    cyc(1);
    io_rd = 1'b0;
  endtask

  // write a whole byte and update the model
  task automatic wr_lane(input int lane, input logic [7:0] v);
    wr(BASE + 12'(lane), v);
    shadow[lane*8 +: 8] = v & ~forced[lane*8 +: 8];
  endtask

  task automatic set_mode(input int line, input logic m);
    logic [7:0] b;
    b = shadow[(line/8)*8 +: 8];
    b[line%8] = m;
    wr_lane(line/8, b);
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    forced = '0;
    forced[0] = 1'b1; forced[1] = 1'b1; forced[2] = 1'b1;
    forced[8] = 1'b1; forced[13] = 1'b1;
    shadow = '0;
    rst_n = 1'b0; io_addr = '0; io_wr = 0; io_rd = 0; io_wdata = '0;
    irq_raw = '0; irq_ack = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    rd(BASE, d);       check("R1 low byte", d, 8'h00);
    rd(BASE + 1, d);   check("R1 high byte", d, 8'h00);
    check("R1 requests", irq_req, 16'h0000);

    // R2 R3 R4 sweep of both bytes
    for (int lane = 0; lane < 2; lane++) begin
      for (int v = 0; v < 256; v++) begin
        wr_lane(lane, 8'(v));
        rd(BASE + 12'(lane), d);
        check("R2 R3 readback", d, 8'(v) & ~forced[lane*8 +: 8]);
        rd(BASE + 12'(1 - lane), d);
        check("R4 other byte kept", d, shadow[(1-lane)*8 +: 8]);
      end
    end

    // R5 unmapped addresses
    wr_lane(0, 8'hFF); wr_lane(1, 8'hFF);
    for (int a = 12'h4C0; a < 12'h4F0; a++) begin
      if (a != BASE && a != BASE + 1) begin
        wr(12'(a), 8'h00);
        rd(12'(a), d);
        check("R5 unmapped read", d, 8'h00);
      end
    end
    rd(BASE, d);     check("R5 low kept", d, shadow[7:0]);
    rd(BASE + 1, d); check("R5 high kept", d, shadow[15:8]);
    io_addr = BASE; io_rd = 1'b0;
    #1 check("R5 idle rdata", io_rdata, 8'h00);
    cyc(1);

    // all lines to edge mode
    wr_lane(0, 8'h00); wr_lane(1, 8'h00);
    cyc(2);

    // R6 R7 R8 edge behaviour on every line
    for (int i = 0; i < 16; i++) begin
      irq_raw[i] = 1'b1;
      cyc(2);  check("R6 edge not yet", irq_req, 16'h0000);
      cyc(1);  check("R6 R7 edge set", irq_req, 16'(1) << i);
      irq_raw[i] = 1'b0;
      cyc(4);  check("R7 held after fall", irq_req, 16'(1) << i);
      irq_ack[i] = 1'b1; cyc(1); irq_ack[i] = 1'b0;
      check("R8 ack clears", irq_req, 16'h0000);
      irq_raw[i] = 1'b1;
      cyc(2);
      irq_ack[i] = 1'b1; cyc(1); irq_ack[i] = 1'b0;
      check("R8 ack with new edge", irq_req, 16'(1) << i);
      irq_ack[i] = 1'b1; cyc(1); irq_ack[i] = 1'b0;
      check("R8 second ack", irq_req, 16'h0000);
      irq_raw[i] = 1'b0;
      cyc(3);
    end

    // R3 R9 R10 level behaviour and mode switching
    for (int i = 0; i < 16; i++) begin
      if (forced[i]) begin
        set_mode(i, 1'b1);
        rd(BASE + 12'(i/8), d);
        check("R3 forced bit reads 0", d[i%8], 1'b0);
        check("R3 forced line stays edge", irq_req[i], 1'b0);
      end else begin
        set_mode(i, 1'b1);
        check("R9 level low input", irq_req[i], 1'b1);
        irq_ack[i] = 1'b1; cyc(1); irq_ack[i] = 1'b0;
        check("R9 ack ignored", irq_req[i], 1'b1);
        irq_raw[i] = 1'b1;
        cyc(1); check("R6 level not yet", irq_req[i], 1'b1);
        cyc(1); check("R6 R9 level released", irq_req[i], 1'b0);
        irq_raw[i] = 1'b0;
        cyc(2); check("R9 level asserted", irq_req[i], 1'b1);
        set_mode(i, 1'b0);
        cyc(1);
        irq_raw[i] = 1'b1;
        cyc(3); check("R10 edge pending", irq_req[i], 1'b1);
        set_mode(i, 1'b1);
        check("R9 level high input", irq_req[i], 1'b0);
        cyc(1);
        set_mode(i, 1'b0);
        check("R10 pending discarded", irq_req[i], 1'b0);
        cyc(2);
        check("R10 no new request", irq_req[i], 1'b0);
        irq_raw[i] = 1'b0;
        cyc(3);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule